// File: doc/BRIEF.md
# Gene-Configured Mesh Filter Array

This block filters an 8-bit unsigned pixel stream with a rectangular mesh of small processing elements. Every element reads one operand from the element above it (north) and one from the element to its left (west). It applies one of sixteen operations and holds the result in a register. That register feeds both the element below and the element to the right. The register of the bottom-right element is the filtered output. Elements on the top row take their north operand from a 3x3 neighbourhood window, and so do elements on the left column for their west operand. Each edge operand has its own input gene, which chooses one of the nine window taps.

The window is built inside the block from a raster stream. The stream arrives one pixel per cycle while `pix_valid_i` is high. Two line delays of `LINE_W` pixels each supply the two older image lines. The window advances one column for every accepted pixel.

The chromosome has one 4-bit function gene per element and one 4-bit input gene per edge operand. It is loaded through a word-wide write port. The mesh computes on every clock. A valid flag runs beside the data with a fixed, parameterised delay, and it marks which output samples belong to the stream.

Top module: `mesh_filter_array`

## Requirements
- R1: After reset `out_pix_o` is 0, `out_valid_o` is 0, and every gene is 0: function code 0 in every element and tap 0 for every edge operand.
- R2: An input gene value g from 0 to 8 selects window tap g in row-major order. Row 0 is the line seen 2*LINE_W pixels earlier, row 2 is the current line, and column 0 is the oldest column. Values 9 to 15 select the centre tap 4.
- R3: Function codes 0 to 6 give: 0 N+W mod 256, 1 2N mod 256, 2 2W mod 256, 3 N+W limited to 255, 4 2N limited to 255, 5 2W limited to 255, 6 floor((N+W)/2) using a 9-bit sum.
- R4: Function codes 7 to 11 give: 7 the constant 255, 8 N>>1, 9 W>>1, 10 N, 11 W.
- R5: Function codes 12 to 15 give: 12 max(N,W), 13 min(N,W), 14 N-W or 0 if N<W, 15 W-N or 0 if W<N.
- R6: On every clock, element (c,r) registers op(N,W), whatever the state of `pix_valid_i`. N is the register of (c,r-1), or for r=0 the tap chosen by top gene c. W is the register of (c-1,r), or for c=0 the tap chosen by left gene r. `out_pix_o` is the register of element (COLS-1,ROWS-1).
- R7: The window shifts, and the line delays advance, only in cycles where `pix_valid_i` is 1. Otherwise every tap keeps its value.
- R8: `out_valid_o` equals `pix_valid_i` delayed by exactly LAT+1 clock cycles.
- R9: A write with `cfg_we_i`=1 stores `cfg_data_i` and is used from the next clock. Address r*COLS+c is the function gene of element (c,r). Address COLS*ROWS+c is top gene c. Address COLS*ROWS+COLS+r is left gene r. Addresses at or above COLS*ROWS+COLS+ROWS change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Raster pixel present this cycle |
| pix_i | input | 8 | Raster pixel |
| cfg_we_i | input | 1 | Gene write strobe |
| cfg_addr_i | input | CFG_AW | Gene address |
| cfg_data_i | input | 4 | Gene value |
| out_valid_o | output | 1 | Output sample belongs to the stream |
| out_pix_o | output | 8 | Register of the bottom-right element |

## Verification
A corrupted element register shows at `out_pix_o` only after it has travelled the Manhattan distance to the bottom-right corner, one cycle per hop. It can also be masked by a downstream operation such as the constant or the pass of the other operand. The bench therefore runs pass-only chromosomes, uniform chromosomes for every code and mixed random ones, and compares the output on every clock. A fault in a window tap or a line delay becomes visible as soon as a gene selects that tap, which can be as late as 2*LINE_W accepted pixels after the fault occurred. The valid flag is compared on every cycle, so an off-by-one in its delay shows at the first edge of each burst.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  localparam int unsigned PIX_W      = 8;
  localparam int unsigned GENE_W     = 4;
  localparam int unsigned WIN_TAPS   = 9;
  localparam int unsigned CENTRE_TAP = 4;

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [GENE_W-1:0] gene_t;

  typedef enum logic [GENE_W-1:0] {
    OP_ADD_NW  = 4'd0,
    OP_ADD_NN  = 4'd1,
    OP_ADD_WW  = 4'd2,
    OP_SAT_NW  = 4'd3,
    OP_SAT_NN  = 4'd4,
    OP_SAT_WW  = 4'd5,
    OP_AVG     = 4'd6,
    OP_ONES    = 4'd7,
    OP_HALF_N  = 4'd8,
    OP_HALF_W  = 4'd9,
    OP_PASS_N  = 4'd10,
    OP_PASS_W  = 4'd11,
    OP_MAX     = 4'd12,
    OP_MIN     = 4'd13,
    OP_SUB_NW  = 4'd14,
    OP_SUB_WN  = 4'd15
  } op_e;

  // out-of-range tap codes fall back to the centre pixel
  function automatic gene_t tap_of(gene_t g);
    return (g < gene_t'(WIN_TAPS)) ? g : gene_t'(CENTRE_TAP);
  endfunction
endpackage

// File: rtl/mfa_line_delay.sv
module mfa_line_delay
  import mfa_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  pix_t d_i,
  output pix_t q_o
);
  pix_t [DEPTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_q <= '0;
    else if (en_i) sr_q <= {sr_q[DEPTH-2:0], d_i};
  end

  assign q_o = sr_q[DEPTH-1];
endmodule

// File: rtl/mfa_window.sv
module mfa_window
  import mfa_pkg::*;
#(
  parameter int unsigned LINE_W = 64
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             en_i,
  input  pix_t                             pix_i,
  output logic                             valid_o,
  output logic [WIN_TAPS-1:0][PIX_W-1:0]   win_o
);
  pix_t line_mid, line_old;

  mfa_line_delay #(.DEPTH(LINE_W)) u_line_mid (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_i), .d_i(pix_i),    .q_o(line_mid)
  );
  mfa_line_delay #(.DEPTH(LINE_W)) u_line_old (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_i), .d_i(line_mid), .q_o(line_old)
  );

  pix_t row_in [3];
  always_comb begin
    row_in[0] = line_old;
    row_in[1] = line_mid;
    row_in[2] = pix_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= en_i;
      if (en_i) begin
        for (int r = 0; r < 3; r++) begin
          win_o[r*3]   <= win_o[r*3+1];
          win_o[r*3+1] <= win_o[r*3+2];
          win_o[r*3+2] <= row_in[r];
        end
      end
    end
  end
endmodule

// File: rtl/mfa_gene_bank.sv
module mfa_gene_bank
  import mfa_pkg::*;
#(
  parameter int unsigned NUM_PE = 36,
  parameter int unsigned NUM_IN = 12,
  parameter int unsigned AW     = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  gene_t                  data_i,
  output gene_t [NUM_PE-1:0]     fn_o,
  output gene_t [NUM_IN-1:0]     in_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fn_o <= '0;
      in_o <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NUM_PE; i++)
        if (addr_i == AW'(i)) fn_o[i] <= data_i;
      for (int k = 0; k < NUM_IN; k++)
        if (addr_i == AW'(NUM_PE + k)) in_o[k] <= data_i;
    end
  end
endmodule

// File: rtl/mfa_pe.sv
module mfa_pe
  import mfa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  op_e  op_i,
  input  pix_t n_i,
  input  pix_t w_i,
  output pix_t q_o
);
  logic [PIX_W:0] s_nw, s_nn, s_ww;
  pix_t           res;

  assign s_nw = {1'b0, n_i} + {1'b0, w_i};
  assign s_nn = {n_i, 1'b0};
  assign s_ww = {w_i, 1'b0};

  always_comb begin
    res = '0;
    case (op_i)
      OP_ADD_NW: res = s_nw[PIX_W-1:0];
      OP_ADD_NN: res = s_nn[PIX_W-1:0];
      OP_ADD_WW: res = s_ww[PIX_W-1:0];
      OP_SAT_NW: res = s_nw[PIX_W] ? '1 : s_nw[PIX_W-1:0];
      OP_SAT_NN: res = s_nn[PIX_W] ? '1 : s_nn[PIX_W-1:0];
      OP_SAT_WW: res = s_ww[PIX_W] ? '1 : s_ww[PIX_W-1:0];
      OP_AVG:    res = s_nw[PIX_W:1];
      OP_ONES:   res = '1;
      OP_HALF_N: res = n_i >> 1;
      OP_HALF_W: res = w_i >> 1;
      OP_PASS_N: res = n_i;
      OP_PASS_W: res = w_i;
      OP_MAX:    res = (n_i > w_i) ? n_i : w_i;
      OP_MIN:    res = (n_i < w_i) ? n_i : w_i;
      OP_SUB_NW: res = (n_i > w_i) ? n_i - w_i : '0;
      OP_SUB_WN: res = (w_i > n_i) ? w_i - n_i : '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= res;
  end
endmodule

// File: rtl/mesh_filter_array.sv
module mesh_filter_array
  import mfa_pkg::*;
#(
  parameter int unsigned COLS   = 6,
  parameter int unsigned ROWS   = 6,
  parameter int unsigned LINE_W = 64,
  parameter int unsigned LAT    = COLS + ROWS - 2,
  parameter int unsigned CFG_AW = $clog2(COLS*ROWS + COLS + ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_valid_i,
  input  logic [7:0]        pix_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [3:0]        cfg_data_i,
  output logic              out_valid_o,
  output logic [7:0]        out_pix_o
);
  localparam int unsigned NUM_PE = COLS * ROWS;
  localparam int unsigned NUM_IN = COLS + ROWS;

  gene_t [NUM_PE-1:0]               fn_genes;
  gene_t [NUM_IN-1:0]               in_genes;
  logic  [WIN_TAPS-1:0][PIX_W-1:0]  win;
  logic                             win_valid;
  pix_t                             edge_pix [NUM_IN];
  pix_t                             pe_n [NUM_PE];
  pix_t                             pe_w [NUM_PE];
  pix_t                             pe_q [NUM_PE];

  mfa_gene_bank #(.NUM_PE(NUM_PE), .NUM_IN(NUM_IN), .AW(CFG_AW)) u_genes (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .data_i (cfg_data_i),
    .fn_o   (fn_genes),
    .in_o   (in_genes)
  );

  mfa_window #(.LINE_W(LINE_W)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (pix_valid_i),
    .pix_i   (pix_i),
    .valid_o (win_valid),
    .win_o   (win)
  );

  // edge operand taps: top row first, then left column
  for (genvar k = 0; k < NUM_IN; k++) begin : g_edge
    assign edge_pix[k] = win[tap_of(in_genes[k])];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int unsigned IDX = r*COLS + c;
      if (r == 0) begin : g_n_edge
        assign pe_n[IDX] = edge_pix[c];
      end else begin : g_n_mesh
        assign pe_n[IDX] = pe_q[IDX-COLS];
      end
      if (c == 0) begin : g_w_edge
        assign pe_w[IDX] = edge_pix[COLS+r];
      end else begin : g_w_mesh
        assign pe_w[IDX] = pe_q[IDX-1];
      end
      mfa_pe u_pe (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .op_i   (op_e'(fn_genes[IDX])),
        .n_i    (pe_n[IDX]),
        .w_i    (pe_w[IDX]),
        .q_o    (pe_q[IDX])
      );
    end
  end

  logic [LAT-1:0] vpipe;
  if (LAT == 1) begin : g_v_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vpipe <= '0;
      else         vpipe <= win_valid;
    end
  end else begin : g_v_many
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vpipe <= '0;
      else         vpipe <= {vpipe[LAT-2:0], win_valid};
    end
  end

  // corner taps for the bound checker
  gene_t br_fn;
  pix_t  br_n, br_w;
  assign br_fn = fn_genes[NUM_PE-1];
  assign br_n  = pe_n[NUM_PE-1];
  assign br_w  = pe_w[NUM_PE-1];

  assign out_valid_o = vpipe[LAT-1];
  assign out_pix_o   = pe_q[NUM_PE-1];
endmodule

// File: rtl/mfa_checker.sv
module mfa_checker
  import mfa_pkg::*;
#(
  parameter int unsigned COLS   = 6,
  parameter int unsigned ROWS   = 6,
  parameter int unsigned LAT    = 10,
  parameter int unsigned CFG_AW = 6
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               pix_valid_i,
  input logic                               cfg_we_i,
  input logic [CFG_AW-1:0]                  cfg_addr_i,
  input logic                               out_valid_i,
  input logic [PIX_W-1:0]                   out_pix_i,
  input logic [GENE_W-1:0]                  br_fn_i,
  input logic [PIX_W-1:0]                   br_n_i,
  input logic [PIX_W-1:0]                   br_w_i,
  input logic [WIN_TAPS*PIX_W-1:0]          win_i,
  input logic [(COLS*ROWS+COLS+ROWS)*GENE_W-1:0] genes_i
);
  localparam int unsigned NGENES = COLS*ROWS + COLS + ROWS;

  logic [LAT:0] ref_v;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_v <= '0;
    else         ref_v <= {ref_v[LAT-1:0], pix_valid_i};
  end

  a_r8_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i == ref_v[LAT]);

  a_r7_window_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> $stable(win_i));

  a_r9_oob_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && (int'(cfg_addr_i) >= int'(NGENES))) |=> $stable(genes_i));

  a_r4_const_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(br_fn_i) == GENE_W'(OP_ONES)) |-> (out_pix_i == '1));

  a_r3_sat_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(br_fn_i) == GENE_W'(OP_SAT_NW)) |->
      (out_pix_i >= $past(br_n_i) && out_pix_i >= $past(br_w_i)));

  a_r5_max_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(br_fn_i) == GENE_W'(OP_MAX)) |->
      (out_pix_i >= $past(br_n_i) && out_pix_i >= $past(br_w_i) &&
       (out_pix_i == $past(br_n_i) || out_pix_i == $past(br_w_i))));
endmodule

bind mesh_filter_array mfa_checker #(
  .COLS(COLS), .ROWS(ROWS), .LAT(LAT), .CFG_AW(CFG_AW)
) u_mfa_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pix_valid_i (pix_valid_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .out_valid_i (out_valid_o),
  .out_pix_i   (out_pix_o),
  .br_fn_i     (br_fn),
  .br_n_i      (br_n),
  .br_w_i      (br_w),
  .win_i       (win),
  .genes_i     ({fn_genes, in_genes})
);

// File: tb/test_mesh_filter_array.sv
`timescale 1ns/1ps
module test_mesh_filter_array;
  localparam int COLS   = 5;
  localparam int ROWS   = 4;
  localparam int LINE_W = 8;
  localparam int LAT    = COLS + ROWS - 2;
  localparam int NPE    = COLS * ROWS;
  localparam int NIN    = COLS + ROWS;
  localparam int NGENE  = NPE + NIN;
  localparam int AW     = $clog2(NGENE);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_valid = 1'b0;
  logic [7:0]    pix = '0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [3:0]    cfg_data = '0;
  logic          out_valid;
  logic [7:0]    out_pix;

  always #4 clk = ~clk;

  mesh_filter_array #(
    .COLS(COLS), .ROWS(ROWS), .LINE_W(LINE_W), .LAT(LAT), .CFG_AW(AW)
  ) i_mesh_filter_array (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pix_valid_i (pix_valid),
    .pix_i       (pix),
    .cfg_we_i    (cfg_we),
    .cfg_addr_i  (cfg_addr),
    .cfg_data_i  (cfg_data),
    .out_valid_o (out_valid),
    .out_pix_o   (out_pix)
  );

  int    checks = 0;
  int    failures = 0;
  string tag = "R1";
  bit    done = 0;

  // behavioural reference state
  int hist[$];
  int win_m [9];
  int pe_m  [ROWS][COLS];
  int fn_m  [NPE];
  int in_m  [NIN];
  bit vs    [LAT+1];

  function automatic int ref_op(int f, int n, int w);
    case (f)
      0:  return (n + w) % 256;
      1:  return (2 * n) % 256;
      2:  return (2 * w) % 256;
      3:  return (n + w > 255) ? 255 : n + w;
      4:  return (2 * n > 255) ? 255 : 2 * n;
      5:  return (2 * w > 255) ? 255 : 2 * w;
      6:  return (n + w) / 2;
      7:  return 255;
      8:  return n / 2;
      9:  return w / 2;
      10: return n;
      11: return w;
      12: return (n > w) ? n : w;
      13: return (n < w) ? n : w;
      14: return (n > w) ? n - w : 0;
      default: return (w > n) ? w - n : 0;
    endcase
  endfunction

  function automatic int tap(int g);
    return (g < 9) ? g : 4;
  endfunction

  function automatic void model_reset();
    hist.delete();
    for (int i = 0; i < 2*LINE_W + 3; i++) hist.push_back(0);
    foreach (win_m[i]) win_m[i] = 0;
    foreach (fn_m[i]) fn_m[i] = 0;
    foreach (in_m[i]) in_m[i] = 0;
    foreach (vs[i]) vs[i] = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) pe_m[r][c] = 0;
  endfunction

  function automatic void model_step();
    int nxt [ROWS][COLS];
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int n, w;
        n = (r == 0) ? win_m[tap(in_m[c])]        : pe_m[r-1][c];
        w = (c == 0) ? win_m[tap(in_m[COLS + r])] : pe_m[r][c-1];
        nxt[r][c] = ref_op(fn_m[r*COLS + c], n, w);
      end
    pe_m = nxt;
    for (int k = LAT; k > 0; k--) vs[k] = vs[k-1];
    vs[0] = pix_valid;
    if (pix_valid) begin
      hist.push_front(int'(pix));
      void'(hist.pop_back());
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++)
          win_m[r*3 + c] = hist[(2 - r)*LINE_W + (2 - c)];
    end
    if (cfg_we) begin
      if (int'(cfg_addr) < NPE)        fn_m[cfg_addr] = int'(cfg_data);
      else if (int'(cfg_addr) < NGENE) in_m[int'(cfg_addr) - NPE] = int'(cfg_data);
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  task automatic check(bit ok, string t, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  // per-cycle comparison; R6 covers the bottom-right output, R8 the flag
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(out_pix) == pe_m[ROWS-1][COLS-1], tag, int'(out_pix), pe_m[ROWS-1][COLS-1]);
      check(out_valid == vs[LAT], "R8 valid delay", int'(out_valid), int'(vs[LAT]));
    end
  end

  task automatic hole();
    @(negedge clk);
    pix_valid = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic push(int p);
    @(negedge clk);
    pix_valid = 1'b1; pix = 8'(p); cfg_we = 1'b0;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    pix_valid = 1'b0; cfg_we = 1'b1; cfg_addr = AW'(a); cfg_data = 4'(d);
  endtask

  function automatic int pick();
    int s;
    s = int'($urandom % 4);
    if (s == 0) return 0;
    if (s == 1) return 255;
    return int'($urandom % 256);
  endfunction

  task automatic stream(int n, int gap_pct);
    for (int i = 0; i < n; i++) begin
      if (int'($urandom % 100) < gap_pct) hole();
      else push(pick());
    end
  endtask

  task automatic set_all_fn(int f);
    for (int i = 0; i < NPE; i++) wr(i, f);
  endtask

  task automatic rand_inputs();
    for (int k = 0; k < NIN; k++) wr(NPE + k, int'($urandom % 16));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_pix == 8'd0, "R1 reset output", int'(out_pix), 0);
    check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);

    // R1 genes all 0: add everywhere, tap 0 on every edge operand
    tag = "R1 reset chromosome";
    stream(3*LINE_W, 5);

    tag = "R2 tap select";
    set_all_fn(10);
    for (int g = 0; g < 16; g++) begin
      wr(NPE + COLS - 1, g);
      stream(2*LINE_W + ROWS + 6, 10);
    end

    tag = "R6 west routing";
    set_all_fn(11);
    for (int g = 0; g < 16; g++) begin
      wr(NPE + COLS + ROWS - 1, g);
      stream(2*LINE_W + COLS + 6, 10);
    end

    tag = "R7 window hold";
    set_all_fn(10);
    for (int g = 0; g < 9; g++) begin
      wr(NPE + COLS - 1, g);
      stream(3*LINE_W, 50);
    end

    for (int op = 0; op < 16; op++) begin
      if (op < 7)       tag = $sformatf("R3 op %0d", op);
      else if (op < 12) tag = $sformatf("R4 op %0d", op);
      else              tag = $sformatf("R5 op %0d", op);
      set_all_fn(op);
      rand_inputs();
      stream(40, 10);
    end

    tag = "R6 mixed chromosome";
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < NPE; i++) wr(i, int'($urandom % 16));
      rand_inputs();
      stream(60, 15);
    end

    tag = "R8 valid bursts";
    for (int b = 0; b < 8; b++) begin
      for (int i = 0; i < b + 1; i++) push(pick());
      for (int i = 0; i < (b % 3) + 1; i++) hole();
    end
    repeat (LAT + 3) hole();

    tag = "R9 out-of-range writes";
    set_all_fn(0);
    wr(NPE, 4);
    wr(NPE + COLS, 4);
    stream(30, 10);
    for (int t = 0; t < 12; t++) begin
      wr(NGENE + int'($urandom % ((1 << AW) - NGENE)), int'($urandom % 16));
      stream(8, 10);
    end
    for (int a = NGENE; a < (1 << AW); a++) begin
      wr(a, 7);
      stream(LAT + 4, 0);
    end

    repeat (LAT + 4) hole();
    done = 1;
    finish_run();
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end
endmodule